// File: doc/BRIEF.md
# EPROM Program-and-Verify Sequencer

This block controls an external programmer that writes a buffer of words into a UV-erasable or one-time-programmable memory. Each word gets one program pulse, then a verify read. A word that reads back wrong gets another pulse, and this repeats until the word reads back correctly or a fixed pulse limit is reached. No extra pulse is applied once a word verifies. When the last address has verified, the programming voltage is removed. Every word is then read back twice: once with the supply at the higher check level, and once at the lower check level.

The block drives the memory's address, its data lines with a separate drive enable, the active-low chip-enable and output-enable strobes, an enable for the programming voltage and a 2-bit supply-level select. It reads the memory's data lines back in. The source word for the current address arrives on `src_word`, indexed by the address the block drives. The analog supplies are outside the block. Their settling is modelled as a timed wait after every level change. All setup, hold and access gaps are counted in clock cycles, derived from a clock-frequency parameter and rounded up.

A run begins with a `start` pulse. It ends with `done` held high and, on failure, `fail` set and `fail_addr` holding the address that failed.

Top module: `eprom_pgm_seq`

## Requirements
- R1: After reset, or when idle, the block holds `mem_e_n` and `mem_g_n` high, `mem_doe`, `vpp_en`, `busy`, `done` and `fail` low, and `vcc_sel` at 0 (nominal).
- R2: A program pulse holds `mem_e_n` low for exactly PULSE cycles. During the pulse `mem_g_n` is high, `vpp_en` is high, `mem_doe` is high and `vcc_sel` is 1 (program level).
- R3: The address, data, data enable, `vpp_en` and `vcc_sel` are unchanged for at least SETUP cycles before `mem_e_n` falls.
- R4: After `mem_e_n` rises, the data stays driven for at least HOLD cycles, and the bus is released (`mem_doe` low) before `mem_g_n` falls. `mem_g_n` falls no sooner than HOLD+OES cycles after the rise. `mem_g_n` is never low while `mem_doe` is high.
- R5: A verify read holds `mem_e_n` high and `mem_g_n` low, and samples `mem_din` at the end of the read. The address does not change while `mem_g_n` is low, nor for FLOAT cycles after it rises.
- R6: A word that fails verify gets another pulse. A word that passes moves on to the next address with no further pulse. Each word therefore receives exactly as many pulses as it needs.
- R7: A word that still fails verify after its 25th pulse ends the run with `fail` set and `fail_addr` equal to that address. No later address is pulsed. A word that first passes on pulse 25 counts as programmed.
- R8: After the last address, `vpp_en` drops. Every word from 0 to `last_addr` is then read with `mem_e_n` and `mem_g_n` both low: first at `vcc_sel`=2 (higher check level), then at `vcc_sel`=3 (lower check level). Each address is read for ACCESS cycles.
- R9: A mismatch between `mem_din` and `src_word` during the check pass ends the run with `fail` set and `fail_addr` equal to the mismatching address.
- R10: `vpp_en` is low before `done` rises. `done`, `fail` and `fail_addr` hold until the next `start`, and `start` clears `fail`.
- R11: Each gap equals ceil(ns × CLK_MHZ / 1000) clock cycles, with a minimum of 1 cycle. The verify read lasts the rounded-up output-enable access time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| last_addr | input | ADDR_W | Highest address to program |
| src_word | input | DATA_W | Buffer word for the address on `mem_addr` |
| mem_din | input | DATA_W | Data read back from the memory |
| mem_addr | output | ADDR_W | Memory address (also buffer index) |
| mem_dout | output | DATA_W | Data driven to the memory |
| mem_doe | output | 1 | Data drive enable |
| mem_e_n | output | 1 | Chip enable / program strobe, active low |
| mem_g_n | output | 1 | Output enable, active low |
| vpp_en | output | 1 | Programming-voltage enable |
| vcc_sel | output | 2 | Supply level: 0 nominal, 1 program, 2 check high, 3 check low |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Run ended in failure |
| fail_addr | output | ADDR_W | Address that failed |

## Verification
Every strobe edge follows a state change by exactly one register, so each gap can be measured on the pins in whole cycles. With CLK_MHZ=2 the gaps are 4 cycles of setup, 200 of pulse, 4 of hold, 4 of release, 1 of read, 1 of float and 1 of check access. The bench samples on the falling clock edge and counts the cycles between strobe and data-enable transitions. It compares those counts with the rounded-up values it computes itself. Pulse counts, programmed contents, read counts per supply level and the failing address are checked only once `done` has risen, by which point every result has settled.

// File: rtl/epgm_pkg.sv
package epgm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PSETTLE,
    ST_LOAD,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_RELEASE,
    ST_VREAD,
    ST_VFLOAT,
    ST_CSETTLE,
    ST_CREAD,
    ST_FDROP,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    LVL_NOM    = 2'd0,
    LVL_PROG   = 2'd1,
    LVL_CHK_HI = 2'd2,
    LVL_CHK_LO = 2'd3
  } vcc_level_e;

  // Convert a duration in ns to clock cycles, rounding up, with a minimum of one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(ns) * longint'(mhz);
    cyc  = (prod + 64'd999) / 64'd1000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/epgm_gap_timer.sv
module epgm_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val - W'(1);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/epgm_retry_ctr.sv
module epgm_retry_ctr #(
  parameter int W     = 5,
  parameter int LIMIT = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         at_limit
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (inc && (cnt_q != W'(LIMIT))) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count    = cnt_q;
  assign at_limit = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/epgm_word_cmp.sv
module epgm_word_cmp #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [DATA_W-1:0] expect_word,
  input  logic [DATA_W-1:0] actual_word,
  output logic              eq_now,
  output logic              eq_q
);
  logic eq_r;

  assign eq_now = (expect_word == actual_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   eq_r <= 1'b0;
    else if (cap) eq_r <= eq_now;
  end

  assign eq_q = eq_r;
endmodule

// File: rtl/eprom_pgm_seq.sv
module eprom_pgm_seq
  import epgm_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 16,
  parameter int CLK_MHZ     = 250,
  parameter int MAX_PULSES  = 25,
  parameter int T_SUPPLY_NS = 10000,
  parameter int T_SETUP_NS  = 2000,
  parameter int T_PULSE_NS  = 100000,
  parameter int T_HOLD_NS   = 2000,
  parameter int T_OES_NS    = 2000,
  parameter int T_OE_NS     = 100,
  parameter int T_DF_NS     = 130,
  parameter int T_ACC_NS    = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] src_word,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  output logic              mem_e_n,
  output logic              mem_g_n,
  output logic              vpp_en,
  output logic [1:0]        vcc_sel,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int unsigned CYC_SUPPLY = ns_to_cyc(T_SUPPLY_NS, CLK_MHZ);
  localparam int unsigned CYC_SETUP  = ns_to_cyc(T_SETUP_NS,  CLK_MHZ);
  localparam int unsigned CYC_PULSE  = ns_to_cyc(T_PULSE_NS,  CLK_MHZ);
  localparam int unsigned CYC_HOLD   = ns_to_cyc(T_HOLD_NS,   CLK_MHZ);
  localparam int unsigned CYC_OES    = ns_to_cyc(T_OES_NS,    CLK_MHZ);
  localparam int unsigned CYC_OE     = ns_to_cyc(T_OE_NS,     CLK_MHZ);
  localparam int unsigned CYC_DF     = ns_to_cyc(T_DF_NS,     CLK_MHZ);
  localparam int unsigned CYC_ACC    = ns_to_cyc(T_ACC_NS,    CLK_MHZ);
  localparam int unsigned CYC_MAX    =
    max2(max2(max2(CYC_SUPPLY, CYC_SETUP), max2(CYC_PULSE, CYC_HOLD)),
         max2(max2(CYC_OES, CYC_OE), max2(CYC_DF, CYC_ACC)));
  localparam int TMR_W = $clog2(CYC_MAX + 1);
  localparam int CNT_W = $clog2(MAX_PULSES + 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] last_q, last_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  vcc_level_e        vcc_q, vcc_d;
  logic              fail_q, fail_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;

  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic              rty_clr, rty_inc;
  logic [CNT_W-1:0]  pulse_cnt;
  logic              rty_at_limit;
  logic              cmp_cap;
  logic              eq_now, eq_q;
  logic [DATA_W-1:0] cmp_expect;
  logic              at_last;

  epgm_gap_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  epgm_retry_ctr #(.W(CNT_W), .LIMIT(MAX_PULSES)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rty_clr),
    .inc      (rty_inc),
    .count    (pulse_cnt),
    .at_limit (rty_at_limit)
  );

  assign cmp_expect = (state_q == ST_CREAD) ? src_word : dout_q;

  epgm_word_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap         (cmp_cap),
    .expect_word (cmp_expect),
    .actual_word (mem_din),
    .eq_now      (eq_now),
    .eq_q        (eq_q)
  );

  assign at_last = (addr_q == last_q);

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    last_d   = last_q;
    dout_d   = dout_q;
    vcc_d    = vcc_q;
    fail_d   = fail_q;
    faddr_d  = faddr_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    rty_clr  = 1'b0;
    rty_inc  = 1'b0;
    cmp_cap  = 1'b0;

    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          addr_d   = '0;
          last_d   = last_addr;
          fail_d   = 1'b0;
          faddr_d  = '0;
          vcc_d    = LVL_PROG;
          state_d  = ST_PSETTLE;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(CYC_SUPPLY);
        end
      end
      ST_PSETTLE: begin
        if (tmr_exp) begin
          state_d  = ST_LOAD;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(1);
        end
      end
      ST_LOAD: begin
        dout_d   = src_word;
        rty_clr  = 1'b1;
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(CYC_SETUP);
      end
      ST_SETUP: begin
        if (tmr_exp) begin
          rty_inc  = 1'b1;
          state_d  = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(CYC_PULSE);
        end
      end
      ST_PULSE: begin
        if (tmr_exp) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(CYC_HOLD);
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          state_d  = ST_RELEASE;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(CYC_OES);
        end
      end
      ST_RELEASE: begin
        if (tmr_exp) begin
          state_d  = ST_VREAD;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(CYC_OE);
        end
      end
      ST_VREAD: begin
        if (tmr_exp) begin
          cmp_cap  = 1'b1;
          state_d  = ST_VFLOAT;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(CYC_DF);
        end
      end
      ST_VFLOAT: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (eq_q) begin
            if (at_last) begin
              addr_d  = '0;
              vcc_d   = LVL_CHK_HI;
              state_d = ST_CSETTLE;
              tmr_val = TMR_W'(CYC_SUPPLY);
            end else begin
              addr_d  = addr_q + ADDR_W'(1);
              state_d = ST_LOAD;
              tmr_val = TMR_W'(1);
            end
          end else if (rty_at_limit) begin
            fail_d  = 1'b1;
            faddr_d = addr_q;
            vcc_d   = LVL_NOM;
            state_d = ST_FDROP;
            tmr_val = TMR_W'(CYC_SUPPLY);
          end else begin
            state_d = ST_SETUP;
            tmr_val = TMR_W'(CYC_SETUP);
          end
        end
      end
      ST_CSETTLE: begin
        if (tmr_exp) begin
          state_d  = ST_CREAD;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(CYC_ACC);
        end
      end
      ST_CREAD: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (!eq_now) begin
            fail_d  = 1'b1;
            faddr_d = addr_q;
            vcc_d   = LVL_NOM;
            state_d = ST_FDROP;
            tmr_val = TMR_W'(CYC_SUPPLY);
          end else if (at_last) begin
            addr_d = '0;
            if (vcc_q == LVL_CHK_HI) begin
              vcc_d   = LVL_CHK_LO;
              state_d = ST_CSETTLE;
              tmr_val = TMR_W'(CYC_SUPPLY);
            end else begin
              vcc_d   = LVL_NOM;
              state_d = ST_DONE;
              tmr_val = TMR_W'(1);
            end
          end else begin
            addr_d  = addr_q + ADDR_W'(1);
            tmr_val = TMR_W'(CYC_ACC);
          end
        end
      end
      ST_FDROP: begin
        if (tmr_exp) begin
          state_d  = ST_DONE;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      last_q  <= '0;
      dout_q  <= '0;
      vcc_q   <= LVL_NOM;
      fail_q  <= 1'b0;
      faddr_q <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      last_q  <= last_d;
      dout_q  <= dout_d;
      vcc_q   <= vcc_d;
      fail_q  <= fail_d;
      faddr_q <= faddr_d;
    end
  end

  // Output decode from registered state
  assign mem_addr  = addr_q;
  assign mem_dout  = dout_q;
  assign mem_doe   = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign mem_e_n   = !((state_q == ST_PULSE) || (state_q == ST_CREAD));
  assign mem_g_n   = !((state_q == ST_VREAD) || (state_q == ST_CREAD));
  assign vpp_en    = (state_q == ST_PSETTLE) || (state_q == ST_LOAD)    ||
                     (state_q == ST_SETUP)   || (state_q == ST_PULSE)   ||
                     (state_q == ST_HOLD)    || (state_q == ST_RELEASE) ||
                     (state_q == ST_VREAD)   || (state_q == ST_VFLOAT);
  assign vcc_sel   = vcc_q;
  assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done      = (state_q == ST_DONE);
  assign fail      = fail_q;
  assign fail_addr = faddr_q;
endmodule

// File: rtl/epgm_chk.sv
module epgm_chk #(
  parameter int ADDR_W     = 18,
  parameter int CNT_W      = 5,
  parameter int MAX_PULSES = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_doe,
  input logic              mem_e_n,
  input logic              mem_g_n,
  input logic              vpp_en,
  input logic [1:0]        vcc_sel,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [CNT_W-1:0]  pulse_cnt
);
  a_r2_pulse_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_e_n && mem_g_n) |-> (vpp_en && mem_doe && vcc_sel == 2'd1));

  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_g_n |-> !mem_doe);

  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_g_n && mem_e_n) |=> $stable(mem_addr));

  a_r8_check_read_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_e_n && !mem_g_n) |-> (!vpp_en && vcc_sel[1]));

  a_r7_pulse_limit: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CNT_W'(MAX_PULSES));

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!vpp_en && !busy && mem_e_n && mem_g_n && !mem_doe));

  a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(fail) && $stable(fail_addr)));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (mem_e_n && mem_g_n && !vpp_en && vcc_sel == 2'd0));
endmodule

bind eprom_pgm_seq epgm_chk #(
  .ADDR_W     (ADDR_W),
  .CNT_W      (CNT_W),
  .MAX_PULSES (MAX_PULSES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_addr  (mem_addr),
  .mem_doe   (mem_doe),
  .mem_e_n   (mem_e_n),
  .mem_g_n   (mem_g_n),
  .vpp_en    (vpp_en),
  .vcc_sel   (vcc_sel),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .fail_addr (fail_addr),
  .pulse_cnt (pulse_cnt)
);

// File: tb/sim_eprom_pgm_seq.sv
module sim_eprom_pgm_seq;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NW = 1 << AW;
  localparam int MHZ = 2;

  function automatic int cyc_of(input int ns);
    int c;
    c = (ns * MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int SETUP_C = (2000 * MHZ + 999) / 1000;
  localparam int PULSE_C = (100000 * MHZ + 999) / 1000;
  localparam int HOLD_C  = (2000 * MHZ + 999) / 1000;
  localparam int OES_C   = (2000 * MHZ + 999) / 1000;
  localparam int OE_C    = 1;  // 100 ns at 2 MHz is 0.2 cycle, rounded up
  localparam int DF_C    = 1;  // 130 ns rounded up
  localparam int ACC_C   = 1;  // 200 ns rounded up

  logic          clk, rst_n, start;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] src_word, mem_din;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_dout;
  logic          mem_doe, mem_e_n, mem_g_n, vpp_en, busy, done, fail;
  logic [1:0]    vcc_sel;

  eprom_pgm_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(MHZ), .MAX_PULSES(25)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .last_addr(last_addr),
    .src_word(src_word), .mem_din(mem_din), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_e_n(mem_e_n),
    .mem_g_n(mem_g_n), .vpp_en(vpp_en), .vcc_sel(vcc_sel), .busy(busy),
    .done(done), .fail(fail), .fail_addr(fail_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Source buffer: top nibble kept below F so no word is all ones
  function automatic logic [DW-1:0] buf_word(input int a);
    return DW'(a * 16'h0321) ^ 16'h0A5C;
  endfunction
  assign src_word = buf_word(int'(mem_addr));

  // Memory model
  logic [DW-1:0] mem [NW];
  int            pulses [NW];
  int            need [NW];
  logic          weak_en;
  logic [AW-1:0] weak_addr;

  always @(posedge mem_e_n or posedge start) begin
    if (start) begin
      for (int i = 0; i < NW; i++) begin
        mem[i]    = '1;
        pulses[i] = 0;
      end
    end else if (vpp_en && mem_g_n && mem_doe && vcc_sel == 2'd1) begin
      pulses[mem_addr] = pulses[mem_addr] + 1;
      if (pulses[mem_addr] >= need[mem_addr])
        mem[mem_addr] = mem[mem_addr] & mem_dout;
    end
  end

  assign mem_din = (!mem_g_n && (!mem_e_n || vpp_en)) ?
                   (mem[mem_addr] ^ ((weak_en && vcc_sel == 2'd3 && mem_addr == weak_addr) ? 16'h0004 : 16'h0000))
                   : 16'h0000;

  // Pin-level timing monitor, sampled on the falling edge
  int cyc, stable_cnt, elow, glow, rise_cyc, grise_cyc;
  int v_width, v_setup, v_hold, v_gap, v_addr, v_done, v_oe, v_order;
  int hi_reads, lo_reads;
  logic [NW-1:0] hi_mask, lo_mask;
  logic lo_seen;
  logic p_e, p_g, p_doe, p_vpp, p_done;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_dout;
  logic [1:0] p_vcc;

  initial cyc = 0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (start) begin
      stable_cnt = 0; elow = 0; glow = 0; rise_cyc = -1000; grise_cyc = -1000;
      v_width = 0; v_setup = 0; v_hold = 0; v_gap = 0; v_addr = 0;
      v_done = 0; v_oe = 0; v_order = 0; hi_reads = 0; lo_reads = 0;
      hi_mask = '0; lo_mask = '0; lo_seen = 1'b0;
    end else begin
      if (mem_addr != p_addr || mem_dout != p_dout || mem_doe != p_doe ||
          vpp_en != p_vpp || vcc_sel != p_vcc) stable_cnt = 0;
      else stable_cnt = stable_cnt + 1;
      if (p_e && !mem_e_n && mem_g_n) begin
        if (stable_cnt < SETUP_C) v_setup++;
        elow = 0;
      end
      if (!mem_e_n && mem_g_n) elow++;
      if (!p_e && mem_e_n && p_g) begin
        if (elow != PULSE_C) v_width++;
        rise_cyc = cyc;
      end
      if (p_doe && !mem_doe && (cyc - rise_cyc) < HOLD_C) v_hold++;
      if (p_g && !mem_g_n && mem_e_n) begin
        if ((cyc - rise_cyc) < HOLD_C + OES_C || mem_doe) v_gap++;
        glow = 0;
      end
      if (!mem_g_n && mem_e_n) glow++;
      if (!p_g && mem_g_n && p_e) begin
        if (glow != OE_C) v_oe++;
        grise_cyc = cyc;
      end
      if (mem_addr != p_addr && vpp_en &&
          (!mem_g_n || (cyc - grise_cyc) < DF_C)) v_addr++;
      if (!mem_e_n && !mem_g_n) begin
        if (vcc_sel == 2'd2) begin
          hi_reads++; hi_mask[mem_addr] = 1'b1;
          if (lo_seen) v_order++;
        end else if (vcc_sel == 2'd3) begin
          lo_reads++; lo_mask[mem_addr] = 1'b1; lo_seen = 1'b1;
        end
      end
      if (done && !p_done && vpp_en) v_done++;
    end
    p_e = mem_e_n; p_g = mem_g_n; p_doe = mem_doe; p_vpp = vpp_en;
    p_done = done; p_addr = mem_addr; p_dout = mem_dout; p_vcc = vcc_sel;
  end

  int n_chk, n_fail;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_once(input string tag);
    int guard;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    // R10: a new start clears the previous failure
    chk(!fail && busy, "R10", {tag, " fail cleared on start"}, fail, 0);
    guard = 0;
    while (!done && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    chk(done, "R10", {tag, " run finished before watchdog"}, done, 1);
  endtask

  task automatic timing_checks(input string tag);
    chk(v_width == 0, "R2",  {tag, " pulse width"},          v_width, 0);
    chk(v_setup == 0, "R3",  {tag, " setup before E"},       v_setup, 0);
    chk(v_hold  == 0, "R4",  {tag, " data hold after E"},    v_hold,  0);
    chk(v_gap   == 0, "R4",  {tag, " release/G gap"},        v_gap,   0);
    chk(v_addr  == 0, "R5",  {tag, " address held"},         v_addr,  0);
    chk(v_oe    == 0, "R11", {tag, " verify read length"},   v_oe,    0);
    chk(v_done  == 0, "R10", {tag, " VPP low before done"},  v_done,  0);
  endtask

  initial begin
    int bad_p, bad_m;
    n_chk = 0; n_fail = 0;
    start = 1'b0; last_addr = AW'(NW - 1); weak_en = 1'b0; weak_addr = '0;
    for (int i = 0; i < NW; i++) need[i] = 1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset and idle pin state
    chk(mem_e_n && mem_g_n && !mem_doe && !vpp_en && vcc_sel == 2'd0 &&
        !busy && !done && !fail, "R1", "reset outputs", {mem_e_n, mem_g_n, mem_doe, vpp_en, busy, done, fail}, 7'b1100000);
    chk(cyc_of(100) == OE_C && cyc_of(100000) == PULSE_C, "R11", "rounding", cyc_of(100), OE_C);

    // Scenario A: 1..4 pulses needed per word, all pass
    for (int i = 0; i < NW; i++) need[i] = (i % 4) + 1;
    run_once("A");
    bad_p = 0; bad_m = 0;
    for (int i = 0; i < NW; i++) begin
      if (pulses[i] != need[i]) bad_p++;
      if (mem[i] != buf_word(i)) bad_m++;
    end
    chk(bad_p == 0, "R6", "A pulses per word equal need", bad_p, 0);
    chk(bad_m == 0, "R6", "A programmed contents", bad_m, 0);
    chk(!fail, "R8", "A no failure", fail, 0);
    chk(hi_reads == NW * ACC_C && hi_mask == '1, "R8", "A high-level reads", hi_reads, NW * ACC_C);
    chk(lo_reads == NW * ACC_C && lo_mask == '1, "R8", "A low-level reads", lo_reads, NW * ACC_C);
    chk(v_order == 0, "R8", "A high before low", v_order, 0);
    timing_checks("A");

    // Scenario B: one word needs exactly the limit
    for (int i = 0; i < NW; i++) need[i] = 1;
    need[5] = 25;
    run_once("B");
    chk(pulses[5] == 25 && !fail, "R7", "B pass on 25th pulse", pulses[5], 25);
    chk(mem[15] == buf_word(15), "R6", "B last word", mem[15], buf_word(15));

    // Scenario C: one word never verifies
    need[5] = 1; need[6] = 26;
    run_once("C");
    chk(fail && fail_addr == 6, "R7", "C fail address", fail_addr, 6);
    chk(pulses[6] == 25, "R7", "C pulses at limit", pulses[6], 25);
    chk(pulses[7] == 0, "R7", "C later word untouched", pulses[7], 0);
    chk(hi_reads == 0, "R7", "C no check pass", hi_reads, 0);
    timing_checks("C");
    repeat (5) @(negedge clk);
    chk(done && fail && fail_addr == 6, "R10", "C result held", fail_addr, 6);

    // Scenario D: word 9 marginal at the low check level
    need[6] = 1; weak_en = 1'b1; weak_addr = 4'd9;
    run_once("D");
    chk(fail && fail_addr == 9, "R9", "D check-pass fail address", fail_addr, 9);
    chk(hi_reads == NW * ACC_C, "R8", "D full high pass", hi_reads, NW * ACC_C);
    chk(lo_reads == 10 * ACC_C, "R9", "D low pass stops at 9", lo_reads, 10 * ACC_C);

    // Scenario E: shorter buffer
    weak_en = 1'b0; last_addr = 4'd2;
    for (int i = 0; i < NW; i++) need[i] = 2;
    run_once("E");
    chk(!fail && pulses[2] == 2 && pulses[3] == 0, "R6", "E stops at last address", pulses[3], 0);
    chk(hi_reads == 3 && lo_reads == 3, "R8", "E reads", hi_reads + lo_reads, 6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule